// File: doc/BRIEF.md
# Shifter-Fed Data Processing ALU

This execution unit carries out one data-processing operation per cycle. The first operand comes straight from a register value. The second operand passes through a preprocessing stage first. That stage either rotates an 8-bit constant or shifts a register value. The shift amount for the register value comes from a small immediate or from the low byte of a third register.

The ALU offers the following operations:
- moves and inverted moves
- the full add and subtract family, including the carry-chained and reversed forms
- the four bitwise operations
- four flag-only comparisons

It returns a result, a destination write enable and the NZCV flags. The caller supplies the current flags on `nzcv_i`. The carry from those flags feeds the carry-chained operations and the shifter special cases. Any flag that an operation leaves alone is copied through. All outputs are registered. They appear one cycle after `valid_i`.

The data width `W` must be a power of two and at least 32.

Top module: `dp_exec_unit`

## Requirements
- R1: On the first rising edge after reset is released, `valid_o` equals the `valid_i` sampled on that edge. When `valid_i` is high, `result_o`, `rd_we_o` and `nzcv_o` reflect that operation. When `valid_i` is low, `result_o` and `nzcv_o` hold their values and `rd_we_o` is 0. While reset is active, all outputs are 0.
- R2: With `imm_sel_i`=1, operand 2 is `imm12_i[7:0]` rotated right by 2×`imm12_i[11:8]`. The shifter carry is bit W-1 of that value when the rotate field is non-zero. Otherwise the shifter carry is the incoming C.
- R3: With `imm_sel_i`=0 and `shift_by_reg_i`=0, `rm_i` is shifted by `shift_imm_i`. `shift_kind_i` selects the shift: 0=LSL, 1=LSR, 2=ASR, 3=ROR. An amount of 0 has special meanings:
  - LSL: passes `rm_i` through with carry = C.
  - LSR and ASR: act as a shift by 32.
  - ROR: rotates right by one through C. The new bit W-1 is C and the carry is bit 0.
- R4: With `shift_by_reg_i`=1, the amount is `rs_i[7:0]`.
  - An amount of 0 passes `rm_i` through with carry = C.
  - LSL by 32 gives 0 with carry = bit 0. LSR by 32 gives 0 with carry = bit 31.
  - LSL or LSR by more than 32 gives 0 with carry 0.
  - ASR by 32 or more fills with the sign bit, with carry = sign.
  - ROR by a non-zero multiple of 32 returns `rm_i` unchanged with carry = bit 31.
- R5: The arithmetic operations produce these results (N = operand 2, C = incoming carry). Every non-compare operation raises `rd_we_o`.

  | Opcode | Result |
  |---|---|
  | 6 | Rn+N |
  | 7 | Rn+N+C |
  | 8 | Rn−N |
  | 9 | Rn−N−!C |
  | 10 | N−Rn |
  | 11 | N−Rn−!C |

- R6: The move and bitwise operations produce these results:

  | Opcode | Result |
  |---|---|
  | 0 | N |
  | 1 | ~N |
  | 2 | Rn&N |
  | 3 | Rn\|N |
  | 4 | Rn^N |
  | 5 | Rn&~N |

- R7: For flag-setting arithmetic, the flags on `nzcv_o` are: `nzcv_o[3]`=N (bit W-1 of the result), `nzcv_o[2]`=Z (result is zero), `nzcv_o[1]`=C (carry out; for subtraction, 1 means no borrow) and `nzcv_o[0]`=V (signed overflow).
- R8: For flag-setting moves and bitwise operations, N and Z follow the result and C is the shifter carry. V is copied from `nzcv_i[0]`.
- R9: Opcodes 12 (Rn&N), 13 (Rn^N), 14 (Rn−N) and 15 (Rn+N) always update the flags and never raise `rd_we_o`. Their flags follow R8 for 12 and 13, and R7 for 14 and 15.
- R10: When `set_flags_i`=0 and the opcode is below 12, `nzcv_o` equals `nzcv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Update flags from this operation |
| rn_i | input | W | First operand |
| imm_sel_i | input | 1 | Operand 2 from rotated immediate |
| imm12_i | input | 12 | Rotate field [11:8], constant [7:0] |
| rm_i | input | W | Register to be shifted |
| shift_kind_i | input | 2 | LSL/LSR/ASR/ROR |
| shift_by_reg_i | input | 1 | Amount taken from rs_i |
| shift_imm_i | input | 5 | Immediate shift amount |
| rs_i | input | W | Register shift amount (low byte used) |
| nzcv_i | input | 4 | Current flags N,Z,C,V |
| valid_o | output | 1 | Result present |
| result_o | output | W | Operation result |
| rd_we_o | output | 1 | Destination write enable |
| nzcv_o | output | 4 | Flags after the operation |

## Verification
Every result, flag set and write enable is due on the first rising edge after the cycle in which `valid_i` is high. The bench drives each operation on a falling edge and compares all three outputs at the next falling edge. At that point exactly one register stage has been crossed and no edge race exists. Idle cycles are checked on the same one-cycle grid to confirm that `valid_o` and `rd_we_o` drop while the result holds.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;

  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_MOVN  = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_CLR   = 4'd5,
    OP_ADD   = 4'd6,
    OP_ADDC  = 4'd7,
    OP_SUB   = 4'd8,
    OP_SUBC  = 4'd9,
    OP_RSUB  = 4'd10,
    OP_RSUBC = 4'd11,
    OP_TEST  = 4'd12,
    OP_TEQ   = 4'd13,
    OP_CMP   = 4'd14,
    OP_CMPN  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_cmp(alu_op_e op);
    return op[3:2] == 2'b11;
  endfunction

endpackage

// File: rtl/imm_rotator.sv
module imm_rotator #(
  parameter int W = 32
) (
  input  logic [11:0]  imm12_i,
  input  logic         cin_i,
  output logic [W-1:0] val_o,
  output logic         cout_o
);
  localparam int SW = $clog2(W);

  logic [W-1:0]  base;
  logic [SW-1:0] rot;

  assign base = {{(W-8){1'b0}}, imm12_i[7:0]};
  assign rot  = SW'({imm12_i[11:8], 1'b0});

  // a rotate of 0 shifts left by W, which yields 0
  assign val_o  = (base >> rot) | (base << (W - int'(rot)));
  assign cout_o = (imm12_i[11:8] == 4'd0) ? cin_i : val_o[W-1];

endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import dp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] rm_i,
  input  logic         cin_i,
  input  shift_kind_e  kind_i,
  input  logic         by_reg_i,
  input  logic [4:0]   imm_amt_i,
  input  logic [W-1:0] rs_i,
  output logic [W-1:0] val_o,
  output logic         cout_o
);
  localparam int SW = $clog2(W);
  localparam int AW = 8;

  logic [AW-1:0]      amt;
  logic               rrx;
  logic [W:0]         lsl_t;
  logic [W:0]         lsr_t;
  logic signed [W:0]  asr_t;
  logic [SW-1:0]      ror_r;
  logic [W-1:0]       ror_v;

  // normalise immediate encodings onto a plain amount
  always_comb begin
    rrx = 1'b0;
    if (by_reg_i) begin
      amt = rs_i[AW-1:0];
    end else begin
      amt = AW'(imm_amt_i);
      if (imm_amt_i == 5'd0) begin
        case (kind_i)
          SH_LSR, SH_ASR: amt = AW'(W);
          SH_ROR:         rrx = 1'b1;
          default:        amt = '0;
        endcase
      end
    end
  end

  assign lsl_t = {1'b0, rm_i} << amt;
  assign lsr_t = {rm_i, 1'b0} >> amt;
  assign asr_t = $signed({rm_i, 1'b0}) >>> amt;
  assign ror_r = amt[SW-1:0];
  assign ror_v = (rm_i >> ror_r) | (rm_i << (W - int'(ror_r)));

  always_comb begin
    if (rrx) begin
      val_o  = {cin_i, rm_i[W-1:1]};
      cout_o = rm_i[0];
    end else if (amt == '0) begin
      val_o  = rm_i;
      cout_o = cin_i;
    end else begin
      case (kind_i)
        SH_LSL: begin
          val_o  = lsl_t[W-1:0];
          cout_o = lsl_t[W];
        end
        SH_LSR: begin
          val_o  = lsr_t[W:1];
          cout_o = lsr_t[0];
        end
        SH_ASR: begin
          val_o  = asr_t[W:1];
          cout_o = asr_t[0];
        end
        default: begin
          val_o  = ror_v;
          cout_o = ror_v[W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import dp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         sh_c_i,
  input  nzcv_t        flags_i,
  output logic [W-1:0] res_o,
  output nzcv_t        flags_o
);
  logic [W-1:0] xa, xb, lres;
  logic         ci, arith, ovf;
  logic [W:0]   sum;

  // one adder: operands swapped or inverted per opcode
  always_comb begin
    xa    = rn_i;
    xb    = op2_i;
    ci    = 1'b0;
    arith = 1'b1;
    case (op_i)
      OP_ADD, OP_CMPN: ;
      OP_ADDC:         ci = flags_i.c;
      OP_SUB, OP_CMP:  begin xb = ~op2_i; ci = 1'b1; end
      OP_SUBC:         begin xb = ~op2_i; ci = flags_i.c; end
      OP_RSUB:         begin xa = op2_i; xb = ~rn_i; ci = 1'b1; end
      OP_RSUBC:        begin xa = op2_i; xb = ~rn_i; ci = flags_i.c; end
      default:         arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, ci};
  assign ovf = (xa[W-1] == xb[W-1]) && (sum[W-1] != xa[W-1]);

  always_comb begin
    case (op_i)
      OP_MOVE:         lres = op2_i;
      OP_MOVN:         lres = ~op2_i;
      OP_AND, OP_TEST: lres = rn_i & op2_i;
      OP_OR:           lres = rn_i | op2_i;
      OP_XOR, OP_TEQ:  lres = rn_i ^ op2_i;
      OP_CLR:          lres = rn_i & ~op2_i;
      default:         lres = '0;
    endcase
  end

  assign res_o     = arith ? sum[W-1:0] : lres;
  assign flags_o.n = res_o[W-1];
  assign flags_o.z = (res_o == '0);
  assign flags_o.c = arith ? sum[W] : sh_c_i;
  assign flags_o.v = arith ? ovf : flags_i.v;

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   opcode_i,
  input  logic         set_flags_i,
  input  logic [W-1:0] rn_i,
  input  logic         imm_sel_i,
  input  logic [11:0]  imm12_i,
  input  logic [W-1:0] rm_i,
  input  logic [1:0]   shift_kind_i,
  input  logic         shift_by_reg_i,
  input  logic [4:0]   shift_imm_i,
  input  logic [W-1:0] rs_i,
  input  logic [3:0]   nzcv_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         rd_we_o,
  output logic [3:0]   nzcv_o
);
  alu_op_e      op;
  nzcv_t        fin, fnew;
  logic [W-1:0] imm_val, sh_val, op2, res;
  logic         imm_c, sh_c, op2_c, cmp;

  assign op  = alu_op_e'(opcode_i);
  assign fin = nzcv_t'(nzcv_i);
  assign cmp = op_is_cmp(op);

  imm_rotator #(.W(W)) u_imm (
    .imm12_i (imm12_i),
    .cin_i   (fin.c),
    .val_o   (imm_val),
    .cout_o  (imm_c)
  );

  op2_shifter #(.W(W)) u_shf (
    .rm_i      (rm_i),
    .cin_i     (fin.c),
    .kind_i    (shift_kind_e'(shift_kind_i)),
    .by_reg_i  (shift_by_reg_i),
    .imm_amt_i (shift_imm_i),
    .rs_i      (rs_i),
    .val_o     (sh_val),
    .cout_o    (sh_c)
  );

  assign op2   = imm_sel_i ? imm_val : sh_val;
  assign op2_c = imm_sel_i ? imm_c : sh_c;

  alu_core #(.W(W)) u_alu (
    .op_i    (op),
    .rn_i    (rn_i),
    .op2_i   (op2),
    .sh_c_i  (op2_c),
    .flags_i (fin),
    .res_o   (res),
    .flags_o (fnew)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      rd_we_o  <= 1'b0;
      nzcv_o   <= '0;
    end else begin
      valid_o <= valid_i;
      rd_we_o <= valid_i & ~cmp;
      if (valid_i) begin
        result_o <= res;
        nzcv_o   <= (set_flags_i || cmp) ? fnew : fin;
      end
    end
  end

endmodule

// File: rtl/dp_exec_unit_chk.sv
module dp_exec_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   opcode_i,
  input logic         set_flags_i,
  input logic [3:0]   nzcv_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         rd_we_o,
  input logic [3:0]   nzcv_o
);
  logic is_cmp, is_logic;
  assign is_cmp   = opcode_i[3:2] == 2'b11;
  assign is_logic = (opcode_i < 4'd6) || (opcode_i == 4'd12) || (opcode_i == 4'd13);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !rd_we_o && $stable(result_o))); // R1
  AST_STORE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_cmp) |=> rd_we_o); // R5
  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_cmp) |=> !rd_we_o); // R9
  AST_ARITH_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && !is_logic) |=> (nzcv_o[3] == result_o[W-1])); // R7
  AST_LOGIC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && is_logic) |=> (nzcv_o[2] == (result_o == '0))); // R8
  AST_LOGIC_V_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (set_flags_i || is_cmp) && is_logic) |=> (nzcv_o[0] == $past(nzcv_i[0]))); // R8
  AST_NOS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !set_flags_i && !is_cmp) |=> (nzcv_o == $past(nzcv_i))); // R10

endmodule

bind dp_exec_unit dp_exec_unit_chk #(.W(W)) u_chk (.*);

// File: tb/dp_exec_unit_tb.sv
`timescale 1ns/1ps
module dp_exec_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   opcode_i = '0;
  logic         set_flags_i = 1'b0;
  logic [W-1:0] rn_i = '0;
  logic         imm_sel_i = 1'b0;
  logic [11:0]  imm12_i = '0;
  logic [W-1:0] rm_i = '0;
  logic [1:0]   shift_kind_i = '0;
  logic         shift_by_reg_i = 1'b0;
  logic [4:0]   shift_imm_i = '0;
  logic [W-1:0] rs_i = '0;
  logic [3:0]   nzcv_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;
  logic         rd_we_o;
  logic [3:0]   nzcv_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dp_exec_unit #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .set_flags_i(set_flags_i), .rn_i(rn_i), .imm_sel_i(imm_sel_i), .imm12_i(imm12_i),
    .rm_i(rm_i), .shift_kind_i(shift_kind_i), .shift_by_reg_i(shift_by_reg_i),
    .shift_imm_i(shift_imm_i), .rs_i(rs_i), .nzcv_i(nzcv_i), .valid_o(valid_o),
    .result_o(result_o), .rd_we_o(rd_we_o), .nzcv_o(nzcv_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // returns {carry, value}
  function automatic logic [32:0] ref_imm(input logic [11:0] f, input logic cin);
    logic [31:0] v = {24'd0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
    return {(f[11:8] == 4'd0) ? cin : v[31], v};
  endfunction

  function automatic logic [32:0] ref_shift(input logic [31:0] rm, input logic cin,
      input logic [1:0] k, input logic byreg, input logic [4:0] i5, input logic [31:0] rs);
    int n;
    logic [31:0] v = rm;
    logic c = cin;
    if (byreg) n = int'(rs[7:0]);
    else begin
      n = int'(i5);
      if (n == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
      if (n == 0 && k == 2'd3) return {rm[0], cin, rm[31:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  // returns {we, nzcv, result}
  function automatic logic [36:0] ref_alu(input logic [3:0] op, input logic s,
      input logic [31:0] a, input logic [31:0] b, input logic shc, input logic [3:0] f);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint u, sv;
    logic [31:0] r;
    logic c, v, ar;
    logic cin = f[1];
    ar = 1'b1;
    u = 0; sv = 0; r = '0;
    case (op)
      4'd6, 4'd15: begin u = ua + ub; sv = sa + sb; end
      4'd7:  begin u = ua + ub + longint'(cin); sv = sa + sb + longint'(cin); end
      4'd8, 4'd14: begin u = ua - ub; sv = sa - sb; end
      4'd9:  begin u = ua - ub - longint'(!cin); sv = sa - sb - longint'(!cin); end
      4'd10: begin u = ub - ua; sv = sb - sa; end
      4'd11: begin u = ub - ua - longint'(!cin); sv = sb - sa - longint'(!cin); end
      default: ar = 1'b0;
    endcase
    if (ar) begin
      r = u[31:0];
      if (op == 4'd6 || op == 4'd7 || op == 4'd15) c = (u > 64'hFFFF_FFFF);
      else c = (u >= 0);
      v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    end else begin
      case (op)
        4'd0: r = b;
        4'd1: r = ~b;
        4'd2, 4'd12: r = a & b;
        4'd3: r = a | b;
        4'd4, 4'd13: r = a ^ b;
        default: r = a & ~b;
      endcase
      c = shc;
      v = f[0];
    end
    if (s || op >= 4'd12) return {op < 4'd12, r[31], r == 0, c, v, r};
    return {op < 4'd12, f, r};
  endfunction

  task automatic run_op(input string rq_res, input string rq_flg, input logic [3:0] op,
      input logic s, input logic [31:0] a, input logic isel, input logic [11:0] i12,
      input logic [31:0] rm, input logic [1:0] k, input logic byreg, input logic [4:0] i5,
      input logic [31:0] rs, input logic [3:0] f);
    logic [32:0] o2;
    logic [36:0] e;
    opcode_i = op; set_flags_i = s; rn_i = a; imm_sel_i = isel; imm12_i = i12;
    rm_i = rm; shift_kind_i = k; shift_by_reg_i = byreg; shift_imm_i = i5;
    rs_i = rs; nzcv_i = f; valid_i = 1'b1;
    o2 = isel ? ref_imm(i12, f[1]) : ref_shift(rm, f[1], k, byreg, i5, rs);
    e  = ref_alu(op, s, a, o2[31:0], o2[32], f);
    @(negedge clk);
    check("R1 valid", 64'(valid_o), 64'd1);
    check(rq_res, 64'(result_o), 64'(e[31:0]));
    check(rq_flg, 64'(nzcv_o), 64'(e[35:32]));
    check((op >= 4'd12) ? "R9 we" : "R5 we", 64'(rd_we_o), 64'(e[36]));
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 64'(valid_o), 64'd0);
    check("R1 reset result", 64'(result_o), 64'd0);
    check("R1 reset nzcv", 64'(nzcv_o), 64'd0);
    check("R1 reset we", 64'(rd_we_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // move with flags, LSL #1 of 0x8000_0004 -> 8, C=1 (R3, R8)
    run_op("R3", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_0004, 2'd0, 1'b0, 5'd1, 0, 4'b0001);
    // 1 - 1 with flags -> Z=1, C=1 (R7)
    run_op("R5", "R7", 4'd8, 1'b1, 1, 1'b1, 12'h001, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0000);
    // reverse subtract 0x77 from imm 0 (R5)
    run_op("R5", "R10", 4'd10, 1'b0, 32'h77, 1'b1, 12'h000, 0, 2'd0, 1'b0, 5'd0, 0, 4'b1010);
    // immediate rotate: 0xFF ror 8 -> 0xFF000000, C from bit 31 (R2)
    run_op("R2", "R8", 4'd0, 1'b1, 0, 1'b1, 12'h4FF, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0000);
    // immediate shift special cases (R3)
    run_op("R3", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_0001, 2'd1, 1'b0, 5'd0, 0, 4'b0000);
    run_op("R3", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_0000, 2'd2, 1'b0, 5'd0, 0, 4'b0000);
    run_op("R3", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h0000_0003, 2'd3, 1'b0, 5'd0, 0, 4'b0010);
    run_op("R3", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h0000_0000, 2'd0, 1'b0, 5'd0, 0, 4'b0010);
    // register shift amounts (R4)
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h0000_0001, 2'd0, 1'b1, 5'd0, 32'd32, 4'b0000);
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_0000, 2'd1, 1'b1, 5'd0, 32'd32, 4'b0000);
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 32'd40, 4'b0010);
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_0000, 2'd2, 1'b1, 5'd0, 32'd200, 4'b0000);
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h8000_1234, 2'd3, 1'b1, 5'd0, 32'd64, 4'b0000);
    run_op("R4", "R8", 4'd0, 1'b1, 0, 1'b0, 0, 32'h1234_5678, 2'd1, 1'b1, 5'd0, 32'hFF00, 4'b0010);
    // logical ops keep V (R6, R8)
    run_op("R6", "R8", 4'd5, 1'b1, 32'hF, 1'b1, 12'h005, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0001);
    run_op("R6", "R8", 4'd3, 1'b1, 32'h0204_0608, 1'b0, 0, 32'h1030_5070, 2'd0, 1'b0, 5'd0, 0, 4'b0001);
    // compares (R9)
    run_op("R9", "R9", 4'd14, 1'b0, 4, 1'b0, 0, 4, 2'd0, 1'b0, 5'd0, 0, 4'b0000);
    run_op("R9", "R9", 4'd15, 1'b0, 32'h7FFF_FFFF, 1'b1, 12'h001, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0000);
    run_op("R9", "R9", 4'd13, 1'b0, 32'hAA, 1'b1, 12'h0AA, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0001);
    // signed overflow and carry chain (R7)
    run_op("R5", "R7", 4'd7, 1'b1, 32'hFFFF_FFFF, 1'b1, 12'h000, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0010);
    run_op("R5", "R7", 4'd9, 1'b1, 32'h8000_0000, 1'b1, 12'h001, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0000);
    run_op("R5", "R7", 4'd11, 1'b1, 5, 1'b1, 12'h003, 0, 2'd0, 1'b0, 5'd0, 0, 4'b0010);

    // idle cycle: valid and write enable drop, result holds (R1)
    hold = result_o;
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 idle valid", 64'(valid_o), 64'd0);
    check("R1 idle we", 64'(rd_we_o), 64'd0);
    check("R1 idle hold", 64'(result_o), 64'(hold));

    // constrained random mix (R2..R10)
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic s = 1'($urandom);
      logic isel = ($urandom_range(0, 3) == 0);
      logic byreg = 1'($urandom);
      logic [31:0] rs = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 40));
      string rr = (op >= 4'd12) ? "R9" : ((op >= 4'd6) ? "R5" : "R6");
      string rf = (op >= 4'd12) ? "R9" : (!s ? "R10" : ((op >= 4'd6) ? "R7" : "R8"));
      run_op(rr, rf, op, s, $urandom, isel, 12'($urandom), $urandom,
             2'($urandom), byreg, 5'($urandom), rs, 4'($urandom));
    end

    valid_i = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule